// File: doc/BRIEF.md
# Block memory micro-op sequencer

This block turns one decoded block-memory instruction into a fixed run of micro-operations for the memory pipeline. A block load or a block store is cracked into eight micro-ops, and a twin load is cracked into two. The caller presents the instruction with a start handshake. The instruction carries an operation kind, the first source register value, and either a second register value or a 13-bit signed immediate chosen by a select bit. It also carries the index of the data register and a flag saying whether the access violates the address-space privilege rules. The sequencer forms the base effective address once when it accepts the instruction. It then emits one micro-op per accepted valid/ready handshake.

Each micro-op carries an address that is 8 bytes past the previous one, a register index that steps with the micro-op number, a store flag, a fault-check enable, and first, last and delayed-commit markers. Alignment and privilege faults are judged only on micro-op 0. A faulting instruction is cut short after micro-op 0 is accepted, and the sequencer reports the fault with a one-cycle pulse and a fault code.

Top module: `blkmem_uop_seq`

## Requirements
- R1: The op kind encoding is 2'b00 block load, 2'b01 block store, 2'b10 or 2'b11 twin load. A block op issues exactly 8 micro-ops with `uop_idx` 0 to 7, and a twin load issues exactly 2 with `uop_idx` 0 and 1. `uop_valid` falls in the cycle after the final micro-op is accepted.
- R2: The base address is rs1 + rs2 when `use_imm` is 0, and rs1 + the sign-extended 13-bit immediate when `use_imm` is 1. Micro-op N presents base + 8*N on `uop_addr`.
- R3: `uop_first` is high only on micro-op 0 and `uop_last` is high only on the final micro-op. `uop_dcommit` is high on every micro-op except the final one.
- R4: `uop_chk_en` is high on micro-op 0 and low on all later micro-ops.
- R5: `uop_reg` is the latched data register index plus the micro-op number, modulo 32. For a twin load this is the low half, then the high half of the pair. `uop_is_store` is high for every micro-op of a block store and low for the loads.
- R6: A fault is judged on the latched base address and privilege flag. Code 2'b01 means privilege; code 2'b10 means misalignment, where a block op needs the low 6 address bits clear and a twin load needs the low 4 bits clear. When both apply the code is 2'b10. In the cycle after a faulting micro-op 0 is accepted, `fault_pulse` is high for exactly one cycle with the code on `fault_code`. `uop_valid` is low at that point and no further micro-ops are issued.
- R7: While `uop_valid` is high and `uop_ready` is low, every micro-op output holds its value. The sequence advances only on a handshake.
- R8: `start_ready` is high only when no sequence is in flight. A `start_valid` raised while busy is ignored and does not disturb the running sequence.
- R9: After reset, `start_ready` is 1 and `uop_valid` and `fault_pulse` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_valid | input | 1 | Instruction offered |
| start_ready | output | 1 | Sequencer idle, instruction taken on this handshake |
| op_kind | input | 2 | Operation kind (see R1) |
| rs1_val | input | ADDR_W (64) | First source register value |
| rs2_val | input | ADDR_W (64) | Second source register value |
| imm_val | input | IMM_W (13) | Signed immediate |
| use_imm | input | 1 | 1 selects the immediate instead of rs2 |
| data_reg | input | REG_W (5) | Data register index of slot 0 |
| priv_viol | input | 1 | Access violates address-space privilege |
| uop_valid | output | 1 | Micro-op presented |
| uop_ready | input | 1 | Memory pipeline accepts the micro-op |
| uop_idx | output | 3 | Micro-op number |
| uop_addr | output | ADDR_W (64) | Effective address |
| uop_reg | output | REG_W (5) | Destination (load) or source (store) register index |
| uop_is_store | output | 1 | Micro-op is a store |
| uop_chk_en | output | 1 | Fault check applies to this micro-op |
| uop_first | output | 1 | First micro-op marker |
| uop_last | output | 1 | Last micro-op marker |
| uop_dcommit | output | 1 | Delayed-commit marker |
| fault_pulse | output | 1 | One-cycle fault report |
| fault_code | output | 2 | 01 privilege, 10 alignment |

## Verification
The bench goes after the fault priority corner, where misalignment and a privilege violation arrive together. A design that checked them in the wrong order would report code 01 instead of 10. It also probes alignment limits: a twin load that is 16-byte but not 64-byte aligned must not fault, so a design that used the block mask for twins would abort it. Register indices near 31 must wrap, or a block op would write past the register file. Random back-pressure and stray start requests during a sequence expose any design that steps its counter without a handshake or restarts mid-run, because the addresses and register indices would then skip or repeat.

// File: rtl/blkmem_pkg.sv
`timescale 1ns/1ps
package blkmem_pkg;

    typedef enum logic [1:0] {
        FLT_NONE  = 2'b00,
        FLT_PRIV  = 2'b01,
        FLT_ALIGN = 2'b10
    } fault_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } state_e;

    typedef struct packed {
        logic is_twin;
        logic is_store;
    } op_class_t;

    // bit 1 selects the two-step pair load; otherwise bit 0 selects store
    function automatic op_class_t classify(input logic [1:0] kind);
        op_class_t c;
        c.is_twin  = kind[1];
        c.is_store = ~kind[1] & kind[0];
        return c;
    endfunction

endpackage

// File: rtl/blkmem_base_gen.sv
`timescale 1ns/1ps
module blkmem_base_gen #(
    parameter int ADDR_W = 64,
    parameter int IMM_W  = 13
) (
    input  logic [ADDR_W-1:0] rs1_val,
    input  logic [ADDR_W-1:0] rs2_val,
    input  logic [IMM_W-1:0]  imm_val,
    input  logic              use_imm,
    output logic [ADDR_W-1:0] base
);
    localparam int EXT_W = ADDR_W - IMM_W;

    logic [ADDR_W-1:0] imm_ext;
    assign imm_ext = {{EXT_W{imm_val[IMM_W-1]}}, imm_val};
    assign base    = rs1_val + (use_imm ? imm_ext : rs2_val);
endmodule

// File: rtl/blkmem_fault_chk.sv
`timescale 1ns/1ps
module blkmem_fault_chk
    import blkmem_pkg::*;
#(
    parameter int BLK_ALIGN_LG  = 6,
    parameter int TWIN_ALIGN_LG = 4
) (
    input  logic [BLK_ALIGN_LG-1:0] base_lo,
    input  logic                    is_twin,
    input  logic                    priv_viol,
    output fault_e                  fault
);
    logic misalign;
    assign misalign = is_twin ? (base_lo[TWIN_ALIGN_LG-1:0] != '0)
                              : (base_lo != '0);

    // lower priority first, so the stronger cause overwrites it
    always_comb begin
        fault = FLT_NONE;
        if (priv_viol) fault = FLT_PRIV;
        if (misalign)  fault = FLT_ALIGN;
    end
endmodule

// File: rtl/blkmem_ctrl.sv
`timescale 1ns/1ps
module blkmem_ctrl
    import blkmem_pkg::*;
#(
    parameter int BLK_UOPS  = 8,
    parameter int TWIN_UOPS = 2,
    parameter int IDX_W     = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_valid,
    input  logic             is_twin,
    input  logic             uop_ready,
    input  fault_e           fault_in,
    output logic             start_ready,
    output logic             uop_valid,
    output logic [IDX_W-1:0] idx,
    output logic             first,
    output logic             last,
    output logic             fault_pulse,
    output fault_e           fault_code
);
    localparam logic [IDX_W-1:0] BLK_LAST  = IDX_W'(BLK_UOPS - 1);
    localparam logic [IDX_W-1:0] TWIN_LAST = IDX_W'(TWIN_UOPS - 1);

    state_e state;
    logic   twin_q;

    assign start_ready = (state == ST_IDLE);
    assign uop_valid   = (state == ST_RUN);
    assign first       = (idx == '0);
    assign last        = (idx == (twin_q ? TWIN_LAST : BLK_LAST));

    always_ff @(posedge clk) begin
        if (rst) begin
            state       <= ST_IDLE;
            idx         <= '0;
            twin_q      <= 1'b0;
            fault_pulse <= 1'b0;
            fault_code  <= FLT_NONE;
        end else begin
            fault_pulse <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (start_valid) begin
                        state  <= ST_RUN;
                        idx    <= '0;
                        twin_q <= is_twin;
                    end
                end
                ST_RUN: begin
                    if (uop_ready) begin
                        if (first && fault_in != FLT_NONE) begin
                            state       <= ST_IDLE;
                            idx         <= '0;
                            fault_pulse <= 1'b1;
                            fault_code  <= fault_in;
                        end else if (last) begin
                            state <= ST_IDLE;
                            idx   <= '0;
                        end else begin
                            idx <= idx + 1'b1;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/blkmem_uop_seq.sv
`timescale 1ns/1ps
module blkmem_uop_seq
    import blkmem_pkg::*;
#(
    parameter int ADDR_W        = 64,
    parameter int IMM_W         = 13,
    parameter int REG_W         = 5,
    parameter int BLK_UOPS      = 8,
    parameter int TWIN_UOPS     = 2,
    parameter int STRIDE        = 8,
    parameter int BLK_ALIGN_LG  = 6,
    parameter int TWIN_ALIGN_LG = 4,
    localparam int IDX_W        = $clog2(BLK_UOPS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_valid,
    output logic              start_ready,
    input  logic [1:0]        op_kind,
    input  logic [ADDR_W-1:0] rs1_val,
    input  logic [ADDR_W-1:0] rs2_val,
    input  logic [IMM_W-1:0]  imm_val,
    input  logic              use_imm,
    input  logic [REG_W-1:0]  data_reg,
    input  logic              priv_viol,
    output logic              uop_valid,
    input  logic              uop_ready,
    output logic [IDX_W-1:0]  uop_idx,
    output logic [ADDR_W-1:0] uop_addr,
    output logic [REG_W-1:0]  uop_reg,
    output logic              uop_is_store,
    output logic              uop_chk_en,
    output logic              uop_first,
    output logic              uop_last,
    output logic              uop_dcommit,
    output logic              fault_pulse,
    output logic [1:0]        fault_code
);
    logic [ADDR_W-1:0] base_w;
    logic [ADDR_W-1:0] base_q;
    op_class_t         cls_in;
    op_class_t         cls_q;
    logic [REG_W-1:0]  reg_q;
    logic              priv_q;
    fault_e            fault_now;
    fault_e            fault_q;
    logic [IDX_W-1:0]  idx;
    logic              first;
    logic              last;

    assign cls_in = classify(op_kind);

    blkmem_base_gen #(.ADDR_W(ADDR_W), .IMM_W(IMM_W)) u_base (
        .rs1_val (rs1_val),
        .rs2_val (rs2_val),
        .imm_val (imm_val),
        .use_imm (use_imm),
        .base    (base_w)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q <= '0;
            cls_q  <= '0;
            reg_q  <= '0;
            priv_q <= 1'b0;
        end else if (start_valid && start_ready) begin
            base_q <= base_w;
            cls_q  <= cls_in;
            reg_q  <= data_reg;
            priv_q <= priv_viol;
        end
    end

    blkmem_fault_chk #(
        .BLK_ALIGN_LG  (BLK_ALIGN_LG),
        .TWIN_ALIGN_LG (TWIN_ALIGN_LG)
    ) u_fault (
        .base_lo   (base_q[BLK_ALIGN_LG-1:0]),
        .is_twin   (cls_q.is_twin),
        .priv_viol (priv_q),
        .fault     (fault_now)
    );

    blkmem_ctrl #(
        .BLK_UOPS  (BLK_UOPS),
        .TWIN_UOPS (TWIN_UOPS),
        .IDX_W     (IDX_W)
    ) u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .start_valid (start_valid),
        .is_twin     (cls_in.is_twin),
        .uop_ready   (uop_ready),
        .fault_in    (fault_now),
        .start_ready (start_ready),
        .uop_valid   (uop_valid),
        .idx         (idx),
        .first       (first),
        .last        (last),
        .fault_pulse (fault_pulse),
        .fault_code  (fault_q)
    );

    assign uop_idx      = idx;
    assign uop_addr     = base_q + ADDR_W'(idx) * ADDR_W'(STRIDE);
    assign uop_reg      = reg_q + REG_W'(idx);
    assign uop_is_store = uop_valid & cls_q.is_store;
    assign uop_first    = uop_valid & first;
    assign uop_last     = uop_valid & last;
    assign uop_dcommit  = uop_valid & ~last;
    assign uop_chk_en   = uop_valid & first;
    assign fault_code   = fault_q;
endmodule

// File: rtl/blkmem_uop_seq_chk.sv
`timescale 1ns/1ps
module blkmem_uop_seq_chk #(
    parameter int ADDR_W = 64,
    parameter int REG_W  = 5,
    parameter int IDX_W  = 3,
    parameter int STRIDE = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              start_ready,
    input logic              uop_valid,
    input logic              uop_ready,
    input logic [IDX_W-1:0]  uop_idx,
    input logic [ADDR_W-1:0] uop_addr,
    input logic [REG_W-1:0]  uop_reg,
    input logic              uop_chk_en,
    input logic              uop_first,
    input logic              uop_last,
    input logic              uop_dcommit,
    input logic              fault_pulse
);
    p_stall_hold_r7: assert property (@(posedge clk) disable iff (rst)
        uop_valid && !uop_ready |=> uop_valid && $stable(uop_addr)
                                    && $stable(uop_idx) && $stable(uop_reg));

    p_stride_r2: assert property (@(posedge clk) disable iff (rst)
        uop_valid && uop_ready && !uop_last |=>
            fault_pulse || (uop_valid && uop_addr == $past(uop_addr) + ADDR_W'(STRIDE)));

    p_last_commit_r3: assert property (@(posedge clk) disable iff (rst)
        uop_valid |-> (uop_last != uop_dcommit));

    p_chk_first_r4: assert property (@(posedge clk) disable iff (rst)
        uop_valid && !uop_first |-> !uop_chk_en);

    p_busy_block_r8: assert property (@(posedge clk) disable iff (rst)
        uop_valid |-> !start_ready);

    p_fault_once_r6: assert property (@(posedge clk) disable iff (rst)
        fault_pulse |=> !fault_pulse);

    p_fault_cause_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(fault_pulse) |-> !uop_valid && $past(uop_valid && uop_ready && uop_first));

    p_end_idle_r1: assert property (@(posedge clk) disable iff (rst)
        uop_valid && uop_ready && uop_last |=> !uop_valid);
endmodule

bind blkmem_uop_seq blkmem_uop_seq_chk #(
    .ADDR_W (ADDR_W),
    .REG_W  (REG_W),
    .IDX_W  (IDX_W),
    .STRIDE (STRIDE)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .start_ready (start_ready),
    .uop_valid   (uop_valid),
    .uop_ready   (uop_ready),
    .uop_idx     (uop_idx),
    .uop_addr    (uop_addr),
    .uop_reg     (uop_reg),
    .uop_chk_en  (uop_chk_en),
    .uop_first   (uop_first),
    .uop_last    (uop_last),
    .uop_dcommit (uop_dcommit),
    .fault_pulse (fault_pulse)
);

// File: tb/blkmem_uop_seq_bench.sv
`timescale 1ns/1ps
module blkmem_uop_seq_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_valid = 1'b0;
    logic        start_ready;
    logic [1:0]  op_kind = '0;
    logic [63:0] rs1_val = '0;
    logic [63:0] rs2_val = '0;
    logic [12:0] imm_val = '0;
    logic        use_imm = 1'b0;
    logic [4:0]  data_reg = '0;
    logic        priv_viol = 1'b0;
    logic        uop_valid;
    logic        uop_ready = 1'b0;
    logic [2:0]  uop_idx;
    logic [63:0] uop_addr;
    logic [4:0]  uop_reg;
    logic        uop_is_store;
    logic        uop_chk_en;
    logic        uop_first;
    logic        uop_last;
    logic        uop_dcommit;
    logic        fault_pulse;
    logic [1:0]  fault_code;

    int checks = 0;
    int failures = 0;

    always #4 clk = ~clk;

    blkmem_uop_seq u_blkmem_uop_seq (
        .clk(clk), .rst(rst), .start_valid(start_valid), .start_ready(start_ready),
        .op_kind(op_kind), .rs1_val(rs1_val), .rs2_val(rs2_val), .imm_val(imm_val),
        .use_imm(use_imm), .data_reg(data_reg), .priv_viol(priv_viol),
        .uop_valid(uop_valid), .uop_ready(uop_ready), .uop_idx(uop_idx),
        .uop_addr(uop_addr), .uop_reg(uop_reg), .uop_is_store(uop_is_store),
        .uop_chk_en(uop_chk_en), .uop_first(uop_first), .uop_last(uop_last),
        .uop_dcommit(uop_dcommit), .fault_pulse(fault_pulse), .fault_code(fault_code)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [63:0] exp_base(input logic [63:0] r1, input logic [63:0] r2,
                                             input logic [12:0] im, input bit ui);
        return r1 + (ui ? {{51{im[12]}}, im} : r2);
    endfunction

    function automatic logic [1:0] exp_fault(input logic [63:0] b, input bit twin, input bit pv);
        logic [1:0] c = 2'b00;
        if (pv) c = 2'b01;
        if (twin ? (b[3:0] != 0) : (b[5:0] != 0)) c = 2'b10;
        return c;
    endfunction

    task automatic run_op(input logic [1:0] op, input logic [63:0] r1, input logic [63:0] r2,
                          input logic [12:0] im, input bit ui, input logic [4:0] rg,
                          input bit pv, input int rdy_pct);
        bit          twin = op[1];
        bit          st   = (op == 2'b01);
        int          n    = twin ? 2 : 8;
        logic [63:0] b    = exp_base(r1, r2, im, ui);
        logic [1:0]  fc   = exp_fault(b, twin, pv);
        int          k    = 0;
        bit          acc;
        @(negedge clk);
        check(start_ready == 1'b1, "R8", "idle start_ready", 64'(start_ready), 64'd1);
        start_valid = 1'b1; op_kind = op; rs1_val = r1; rs2_val = r2;
        imm_val = im; use_imm = ui; data_reg = rg; priv_viol = pv;
        @(posedge clk);
        @(negedge clk);
        start_valid = 1'b0;
        op_kind = 2'($urandom); rs1_val = {$urandom, $urandom}; data_reg = 5'($urandom);
        while (1) begin
            check(uop_valid == 1'b1, "R1", "uop_valid in run", 64'(uop_valid), 64'd1);
            check(uop_idx == 3'(k), "R1", "uop_idx", 64'(uop_idx), 64'(k));
            check(uop_addr == b + 64'(k * 8), "R2", "uop_addr", uop_addr, b + 64'(k * 8));
            check({uop_first, uop_last, uop_dcommit} == {k == 0, k == n - 1, k != n - 1},
                  "R3", "first/last/dcommit", 64'({uop_first, uop_last, uop_dcommit}),
                  64'({k == 0, k == n - 1, k != n - 1}));
            check(uop_chk_en == (k == 0), "R4", "uop_chk_en", 64'(uop_chk_en), 64'(k == 0));
            check(uop_reg == 5'(rg + k), "R5", "uop_reg", 64'(uop_reg), 64'(5'(rg + k)));
            check(uop_is_store == st, "R5", "uop_is_store", 64'(uop_is_store), 64'(st));
            check(start_ready == 1'b0, "R8", "busy start_ready", 64'(start_ready), 64'd0);
            uop_ready   = (($urandom % 100) < rdy_pct);
            start_valid = 1'($urandom);
            @(posedge clk);
            acc = uop_ready;
            @(negedge clk);
            if (acc) begin
                if (k == 0 && fc != 2'b00) begin
                    start_valid = 1'b0;
                    check(fault_pulse == 1'b1, "R6", "fault_pulse", 64'(fault_pulse), 64'd1);
                    check(fault_code == fc, "R6", "fault_code", 64'(fault_code), 64'(fc));
                    check(uop_valid == 1'b0, "R6", "suppressed after fault", 64'(uop_valid), 64'd0);
                    uop_ready = 1'b0;
                    @(negedge clk);
                    check(fault_pulse == 1'b0, "R6", "fault pulse width", 64'(fault_pulse), 64'd0);
                    break;
                end
                check(fault_pulse == 1'b0, "R6", "no fault pulse", 64'(fault_pulse), 64'd0);
                if (k == n - 1) begin
                    start_valid = 1'b0;
                    check(uop_valid == 1'b0, "R1", "end of run", 64'(uop_valid), 64'd0);
                    break;
                end
                k++;
            end
        end
        start_valid = 1'b0;
        uop_ready   = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog: actual=expired expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        check(start_ready == 1'b1, "R9", "reset start_ready", 64'(start_ready), 64'd1);
        check(uop_valid == 1'b0, "R9", "reset uop_valid", 64'(uop_valid), 64'd0);
        check(fault_pulse == 1'b0, "R9", "reset fault_pulse", 64'(fault_pulse), 64'd0);

        // R1 R2 block load register form, always ready
        run_op(2'b00, 64'h1000, 64'h0040, 13'h0, 1'b0, 5'd0, 1'b0, 100);
        // R2 block store with negative immediate, back-pressure
        run_op(2'b01, 64'h2000, 64'h0, 13'h1FC0, 1'b1, 5'd8, 1'b0, 40);
        // R5 register index wraps past 31
        run_op(2'b00, 64'h4000, 64'h0, 13'h0, 1'b1, 5'd30, 1'b0, 70);
        // R1 twin load, both encodings
        run_op(2'b10, 64'h3010, 64'h0, 13'h0, 1'b0, 5'd4, 1'b0, 100);
        run_op(2'b11, 64'h3000, 64'h20, 13'h0, 1'b0, 5'd31, 1'b0, 50);
        // R6 block misaligned only by 16: alignment fault
        run_op(2'b00, 64'h5010, 64'h0, 13'h0, 1'b0, 5'd2, 1'b0, 100);
        // R6 privilege only
        run_op(2'b01, 64'h6000, 64'h0, 13'h0, 1'b0, 5'd2, 1'b1, 60);
        // R6 both: alignment wins
        run_op(2'b00, 64'h6004, 64'h0, 13'h0, 1'b0, 5'd2, 1'b1, 100);
        // R6 twin misaligned by 8
        run_op(2'b10, 64'h7008, 64'h0, 13'h0, 1'b1, 5'd6, 1'b0, 100);
        // R7 heavy stall
        run_op(2'b01, 64'h8000, 64'h100, 13'h0, 1'b0, 5'd16, 1'b0, 15);

        for (int i = 0; i < 60; i++) begin
            logic [63:0] r1 = {$urandom, $urandom} & ~64'h3F;
            logic [63:0] r2 = {$urandom, $urandom} & ~64'h3F;
            logic [12:0] im = 13'($urandom) & ~13'h3F;
            if ($urandom % 4 == 0) r1 = r1 + 64'($urandom % 64);
            run_op(2'($urandom), r1, r2, im, 1'($urandom), 5'($urandom),
                   ($urandom % 6 == 0), 20 + int'($urandom % 81));
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule